// File: doc/BRIEF.md
# Locked Indexed Configuration Register File

This block holds the byte-wide configuration registers of a system chipset. Software reaches them through two ports: a write to the index port selects a register. A later write to the data port stores a byte into the selected register. Each index keeps only the bits its write mask allows. Indices that hold no register drop the write and read back as zero.

All registers except the lock-key register are protected. A data write to any other index is accepted only while the key register holds the unlock value. The key register itself can always be written. Some stored fields are decoded into side-band outputs for neighbouring logic:

- cache enables
- the fast-reset/A20 port decode enable
- four PCI interrupt routing codes
- one-cycle recalculation strobes for the shadow-memory logic and the SMM logic

Reads are combinational and return the selected register. While the CPU-conflict input is high, a small set of indices reads as all ones so that they do not collide with CPU-internal registers.

Top module: `cfg_regfile`

## Requirements
- R1: A cycle with `idx_we_i` high latches `wdata_i` as the index. A data write in the same cycle goes to the previously latched index, and the new index applies from the next cycle.
- R2: After reset, every register reads 0x00 and the block is locked. All enables, strobes and valid flags are 0.
- R3: Index 0x03 is the key register and is written on every data write to it, whether locked or not. The block is unlocked exactly while this register holds 0xC5.
- R4: While locked, a data write to any index other than 0x03 leaves every register and output unchanged.
- R5: Masked indices store the written byte ANDed with their mask: 0x14→0xBF, 0x15→0xF1, 0x1E→0x40, 0x22→0xFD, 0x2B→0xBF, 0x36→0xE5, 0x37→0xEF, 0x3D→0x07, 0x40→0x3F.
- R6: These indices store the full byte: 0x10–0x13, 0x16, 0x17, 0x19–0x1C, 0x20, 0x21, 0x25–0x2A, 0x30–0x35, 0x38–0x3C, 0x3F, 0x41–0x44. Writes to every other index (except 0x03) are ignored, and those indices read 0x00.
- R7: `cache_int_en_o` follows bit 0 of register 0x16, and `cache_ext_en_o` follows bit 1 of it.
- R8: `port92_en_o` follows bit 4 of register 0x29.
- R9: An accepted data write to 0x13 or 0x14 raises `shadow_upd_o` for exactly the cycle after the write. An accepted data write to 0x19 does the same for `smm_upd_o`. No other write raises either strobe.
- R10: `irq_code_o` fields are set as follows: [3:0] = 0x42[3:0] (INTA), [7:4] = 0x42[7:4] (INTB), [11:8] = 0x43[3:0] (INTC), [15:12] = 0x43[7:4] (INTD). `irq_vld_o[k]` is 1 exactly when field k is non-zero; a code of 0 means the line is disabled.
- R11: While `cpu_conflict_i` is high and the index is 0x20 or at least 0xC0, `rd_data_o` is 0xFF.
- R12: Otherwise `rd_data_o` is the stored value of the latched index, also while locked. Reading never changes state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_we_i | input | 1 | Index port write |
| data_we_i | input | 1 | Data port write |
| wdata_i | input | 8 | Write byte shared by both ports |
| cpu_conflict_i | input | 1 | Hide indices that overlap CPU registers |
| rd_data_o | output | 8 | Data port read value |
| cache_int_en_o | output | 1 | Internal cache enable |
| cache_ext_en_o | output | 1 | External cache enable |
| port92_en_o | output | 1 | Fast-reset/A20 port decode enable |
| shadow_upd_o | output | 1 | Shadow-memory recalculation strobe |
| smm_upd_o | output | 1 | SMM recalculation strobe |
| irq_code_o | output | 16 | Four 4-bit IRQ routing codes, INTA in the low nibble |
| irq_vld_o | output | 4 | Routing code non-zero, one bit per line |

## Verification
The index port write and the data port write can occur in the same cycle on the shared byte bus. The bench first writes a known value to the target of the new index. It then drives both strobes in one cycle while a different index is latched. It judges the outcome by reading the old target, which must hold the byte, and the new target, which must be untouched and must now be the one selected. Strobe timing is sampled at the half cycle after the write edge and again one cycle later, which separates a one-cycle pulse from a level.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int CFG_DW = 8;
  localparam int CFG_AW = 8;

  // zero mask = no storage at this index
  function automatic logic [CFG_DW-1:0] cfg_mask(input logic [CFG_AW-1:0] idx);
    case (idx)
      8'h03, 8'h10, 8'h11, 8'h12, 8'h13: cfg_mask = 8'hFF;
      8'h14: cfg_mask = 8'hBF;
      8'h15: cfg_mask = 8'hF1;
      8'h16, 8'h17: cfg_mask = 8'hFF;
      8'h19, 8'h1A, 8'h1B, 8'h1C: cfg_mask = 8'hFF;
      8'h1E: cfg_mask = 8'h40;
      8'h20, 8'h21: cfg_mask = 8'hFF;
      8'h22: cfg_mask = 8'hFD;
      8'h25, 8'h26, 8'h27, 8'h28, 8'h29, 8'h2A: cfg_mask = 8'hFF;
      8'h2B: cfg_mask = 8'hBF;
      8'h30, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35: cfg_mask = 8'hFF;
      8'h36: cfg_mask = 8'hE5;
      8'h37: cfg_mask = 8'hEF;
      8'h38, 8'h39, 8'h3A, 8'h3B, 8'h3C: cfg_mask = 8'hFF;
      8'h3D: cfg_mask = 8'h07;
      8'h3F: cfg_mask = 8'hFF;
      8'h40: cfg_mask = 8'h3F;
      8'h41, 8'h42, 8'h43, 8'h44: cfg_mask = 8'hFF;
      default: cfg_mask = 8'h00;
    endcase
  endfunction

  localparam logic [CFG_AW-1:0] IDX_CACHE  = 8'h16;
  localparam logic [CFG_AW-1:0] IDX_CLK    = 8'h29;
  localparam logic [CFG_AW-1:0] IDX_ROUTE0 = 8'h42;
  localparam logic [CFG_AW-1:0] IDX_ROUTE1 = 8'h43;
  localparam logic [CFG_AW-1:0] IDX_SHD0   = 8'h13;
  localparam logic [CFG_AW-1:0] IDX_SHD1   = 8'h14;
  localparam logic [CFG_AW-1:0] IDX_SMM    = 8'h19;
  localparam logic [CFG_AW-1:0] IDX_HIDE   = 8'h20;
  localparam logic [CFG_AW-1:0] IDX_HIDE_HI = 8'hC0;
endpackage

// File: rtl/cfg_index_latch.sv
module cfg_index_latch
  import cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_we_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output logic [CFG_AW-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_o <= '0;
    else if (idx_we_i) idx_o <= wdata_i;
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_pkg::*;
#(
  parameter int NUM_REGS = 69
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_ok_i,
  input  logic [CFG_AW-1:0]          wr_idx_i,
  input  logic [CFG_DW-1:0]          wdata_i,
  output logic [NUM_REGS*CFG_DW-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [CFG_DW-1:0] MASK = cfg_mask(CFG_AW'(g));
    if (MASK != '0) begin : g_store
      logic [CFG_DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                   q <= '0;
        else if (wr_ok_i && wr_idx_i == CFG_AW'(g))    q <= wdata_i & MASK;
      end
      assign regs_o[g*CFG_DW +: CFG_DW] = q;
    end else begin : g_hole
      assign regs_o[g*CFG_DW +: CFG_DW] = '0;
    end
  end
endmodule

// File: rtl/cfg_side_decode.sv
module cfg_side_decode
  import cfg_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_ok_i,
  input  logic [CFG_AW-1:0]      wr_idx_i,
  input  logic [1:0]             cache_bits_i,
  input  logic                   p92_bit_i,
  input  logic [NUM_IRQ*4-1:0]   route_i,
  output logic                   cache_int_en_o,
  output logic                   cache_ext_en_o,
  output logic                   port92_en_o,
  output logic                   shadow_upd_o,
  output logic                   smm_upd_o,
  output logic [NUM_IRQ*4-1:0]   irq_code_o,
  output logic [NUM_IRQ-1:0]     irq_vld_o
);
  assign cache_int_en_o = cache_bits_i[0];
  assign cache_ext_en_o = cache_bits_i[1];
  assign port92_en_o    = p92_bit_i;

  logic shd_hit, smm_hit;
  assign shd_hit = wr_ok_i && (wr_idx_i == IDX_SHD0 || wr_idx_i == IDX_SHD1);
  assign smm_hit = wr_ok_i && (wr_idx_i == IDX_SMM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_upd_o <= 1'b0;
      smm_upd_o    <= 1'b0;
    end else begin
      shadow_upd_o <= shd_hit;
      smm_upd_o    <= smm_hit;
    end
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    assign irq_code_o[k*4 +: 4] = route_i[k*4 +: 4];
    assign irq_vld_o[k]         = |route_i[k*4 +: 4];
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_pkg::*;
#(
  parameter int NUM_REGS = 69
) (
  input  logic [CFG_AW-1:0]          idx_i,
  input  logic                       conflict_i,
  input  logic [NUM_REGS*CFG_DW-1:0] regs_i,
  output logic [CFG_DW-1:0]          rd_data_o
);
  logic hidden;
  assign hidden = conflict_i && (idx_i == IDX_HIDE || idx_i >= IDX_HIDE_HI);

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx_i == CFG_AW'(i)) rd_data_o = regs_i[i*CFG_DW +: CFG_DW];
    if (hidden) rd_data_o = '1;
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_pkg::*;
#(
  parameter int                NUM_REGS = 69,
  parameter logic [CFG_AW-1:0] LOCK_IDX = 8'h03,
  parameter logic [CFG_DW-1:0] LOCK_KEY = 8'hC5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        idx_we_i,
  input  logic        data_we_i,
  input  logic [7:0]  wdata_i,
  input  logic        cpu_conflict_i,
  output logic [7:0]  rd_data_o,
  output logic        cache_int_en_o,
  output logic        cache_ext_en_o,
  output logic        port92_en_o,
  output logic        shadow_upd_o,
  output logic        smm_upd_o,
  output logic [15:0] irq_code_o,
  output logic [3:0]  irq_vld_o
);
  localparam int NUM_IRQ = 4;

  logic [CFG_AW-1:0]          idx_q;
  logic [NUM_REGS*CFG_DW-1:0] regs_flat;
  logic                       unlocked;
  logic                       wr_ok;

  cfg_index_latch u_idx (
    .clk_i, .rst_ni, .idx_we_i, .wdata_i, .idx_o(idx_q)
  );

  assign unlocked = regs_flat[int'(LOCK_IDX)*CFG_DW +: CFG_DW] == LOCK_KEY;
  assign wr_ok    = data_we_i && (unlocked || idx_q == LOCK_IDX);

  cfg_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk_i, .rst_ni,
    .wr_ok_i (wr_ok),
    .wr_idx_i(idx_q),
    .wdata_i,
    .regs_o  (regs_flat)
  );

  cfg_side_decode #(.NUM_IRQ(NUM_IRQ)) u_side (
    .clk_i, .rst_ni,
    .wr_ok_i       (wr_ok),
    .wr_idx_i      (idx_q),
    .cache_bits_i  (regs_flat[int'(IDX_CACHE)*CFG_DW +: 2]),
    .p92_bit_i     (regs_flat[int'(IDX_CLK)*CFG_DW + 4]),
    .route_i       ({regs_flat[int'(IDX_ROUTE1)*CFG_DW +: CFG_DW],
                     regs_flat[int'(IDX_ROUTE0)*CFG_DW +: CFG_DW]}),
    .cache_int_en_o, .cache_ext_en_o, .port92_en_o,
    .shadow_upd_o, .smm_upd_o, .irq_code_o, .irq_vld_o
  );

  cfg_read_mux #(.NUM_REGS(NUM_REGS)) u_rd (
    .idx_i     (idx_q),
    .conflict_i(cpu_conflict_i),
    .regs_i    (regs_flat),
    .rd_data_o
  );
endmodule

// File: rtl/cfg_regfile_chk.sv
module cfg_regfile_chk #(
  parameter int NUM_REGS = 69
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 idx_we_i,
  input logic                 data_we_i,
  input logic [7:0]           wdata_i,
  input logic                 cpu_conflict_i,
  input logic [7:0]           rd_data_o,
  input logic                 cache_int_en_o,
  input logic                 shadow_upd_o,
  input logic                 smm_upd_o,
  input logic [7:0]           idx_q,
  input logic                 wr_ok,
  input logic [NUM_REGS*8-1:0] regs_flat
);
  // R1
  idx_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(idx_we_i) |-> idx_q == $past(wdata_i));

  // R4
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i && idx_q != 8'h03 && regs_flat[3*8 +: 8] != 8'hC5 |=> $stable(regs_flat));

  // R5
  mask_1e_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_flat[8'h1E*8 +: 8] & 8'hBF) == 8'h00);

  // R7
  cache_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_int_en_o != $past(cache_int_en_o) |-> $past(wr_ok && idx_q == 8'h16));

  // R9
  shadow_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shadow_upd_o |-> $past(wr_ok && (idx_q == 8'h13 || idx_q == 8'h14)));

  // R9
  smm_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smm_upd_o |-> $past(wr_ok && idx_q == 8'h19));

  // R11
  hide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_conflict_i && (idx_q == 8'h20 || idx_q >= 8'hC0) |-> rd_data_o == 8'hFF);
endmodule

bind cfg_regfile cfg_regfile_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i, .rst_ni, .idx_we_i, .data_we_i, .wdata_i, .cpu_conflict_i,
  .rd_data_o, .cache_int_en_o, .shadow_upd_o, .smm_upd_o,
  .idx_q, .wr_ok, .regs_flat
);

// File: tb/cfg_regfile_bench.sv
module cfg_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        idx_we = 1'b0, data_we = 1'b0, conflict = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rd_data;
  logic        c_int, c_ext, p92, shd, smm;
  logic [15:0] irq_code;
  logic [3:0]  irq_vld;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_regfile u_cfg_regfile (
    .clk_i(clk), .rst_ni, .idx_we_i(idx_we), .data_we_i(data_we),
    .wdata_i(wdata), .cpu_conflict_i(conflict), .rd_data_o(rd_data),
    .cache_int_en_o(c_int), .cache_ext_en_o(c_ext), .port92_en_o(p92),
    .shadow_upd_o(shd), .smm_upd_o(smm), .irq_code_o(irq_code), .irq_vld_o(irq_vld)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_idx(input logic [7:0] v);
    @(negedge clk); idx_we = 1'b1; wdata = v;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); data_we = 1'b1; wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] v);
    wr_idx(i); wr_dat(v);
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] v);
    wr_idx(i); #1 v = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R2 cache_int", c_int, 0);
    chk("R2 cache_ext", c_ext, 0);
    chk("R2 port92", p92, 0);
    chk("R2 strobes", {shd, smm}, 0);
    chk("R2 irq_vld", irq_vld, 0);
    rd_reg(8'h03, v); chk("R2 key", v, 8'h00);
    rd_reg(8'h16, v); chk("R2 reg16", v, 8'h00);
  endtask

  task automatic t_locked;
    logic [7:0] v;
    wr_reg(8'h16, 8'h03);
    chk("R4 cache outs locked", {c_int, c_ext}, 0);
    rd_reg(8'h16, v); chk("R4 reg16 locked", v, 8'h00);
    wr_reg(8'h13, 8'h55);
    chk("R4 no shadow strobe locked", shd, 0);
    wr_reg(8'h03, 8'hC4);
    rd_reg(8'h03, v); chk("R3 key writable", v, 8'hC4);
    wr_reg(8'h10, 8'h12);
    rd_reg(8'h10, v); chk("R4 wrong key", v, 8'h00);
  endtask

  task automatic t_unlock;
    logic [7:0] v;
    wr_reg(8'h03, 8'hC5);
    rd_reg(8'h03, v); chk("R3 key", v, 8'hC5);
    wr_reg(8'h10, 8'hA5);
    rd_reg(8'h10, v); chk("R3 unlocked write", v, 8'hA5);
  endtask

  task automatic t_masks;
    logic [7:0] idx [9] = '{8'h14, 8'h15, 8'h1E, 8'h22, 8'h2B, 8'h36, 8'h37, 8'h3D, 8'h40};
    logic [7:0] msk [9] = '{8'hBF, 8'hF1, 8'h40, 8'hFD, 8'hBF, 8'hE5, 8'hEF, 8'h07, 8'h3F};
    logic [7:0] v;
    for (int i = 0; i < 9; i++) begin
      wr_reg(idx[i], 8'hFF);
      rd_reg(idx[i], v); chk($sformatf("R5 mask idx %h", idx[i]), v, msk[i]);
    end
  endtask

  task automatic t_full;
    logic [7:0] v;
    wr_reg(8'h3F, 8'h5A);
    rd_reg(8'h3F, v); chk("R6 full 3f", v, 8'h5A);
    wr_reg(8'h44, 8'hC3);
    rd_reg(8'h44, v); chk("R6 full 44", v, 8'hC3);
    wr_reg(8'h18, 8'hFF);
    rd_reg(8'h18, v); chk("R6 hole 18", v, 8'h00);
    wr_reg(8'h50, 8'hFF);
    rd_reg(8'h50, v); chk("R6 out of range 50", v, 8'h00);
  endtask

  task automatic t_cache_p92;
    wr_reg(8'h16, 8'h01);
    chk("R7 int only", {c_ext, c_int}, 2'b01);
    wr_reg(8'h16, 8'hFE);
    chk("R7 ext only", {c_ext, c_int}, 2'b10);
    wr_reg(8'h29, 8'h10);
    chk("R8 port92 on", p92, 1);
    wr_reg(8'h29, 8'hEF);
    chk("R8 port92 off", p92, 0);
  endtask

  task automatic t_strobe;
    wr_idx(8'h13); wr_dat(8'h01);
    chk("R9 shadow 13 pulse", {shd, smm}, 2'b10);
    @(negedge clk); chk("R9 shadow 13 drop", shd, 0);
    wr_idx(8'h14); wr_dat(8'h01);
    chk("R9 shadow 14 pulse", {shd, smm}, 2'b10);
    @(negedge clk); chk("R9 shadow 14 drop", shd, 0);
    wr_idx(8'h19); wr_dat(8'h01);
    chk("R9 smm pulse", {shd, smm}, 2'b01);
    @(negedge clk); chk("R9 smm drop", smm, 0);
    wr_idx(8'h12); wr_dat(8'h01);
    chk("R9 no strobe 12", {shd, smm}, 2'b00);
  endtask

  task automatic t_irq;
    wr_reg(8'h42, 8'h5A);
    wr_reg(8'h43, 8'h0B);
    chk("R10 codes", irq_code, 16'h0B5A);
    chk("R10 valid", irq_vld, 4'b0111);
    wr_reg(8'h42, 8'hF0);
    chk("R10 inta disabled", {irq_code[7:0], irq_vld}, {8'hF0, 4'b0110});
  endtask

  task automatic t_conflict;
    logic [7:0] v;
    wr_reg(8'h20, 8'h77);
    wr_reg(8'h21, 8'h66);
    rd_reg(8'h20, v); chk("R12 idx20 visible", v, 8'h77);
    @(negedge clk); conflict = 1'b1; #1;
    chk("R11 idx20 hidden", rd_data, 8'hFF);
    rd_reg(8'hC0, v); chk("R11 idx c0 hidden", v, 8'hFF);
    rd_reg(8'h21, v); chk("R11 idx21 visible", v, 8'h66);
    @(negedge clk); conflict = 1'b0;
  endtask

  task automatic t_same_cycle;
    logic [7:0] v;
    wr_reg(8'h1A, 8'h66);
    wr_reg(8'h17, 8'h00);
    @(negedge clk); idx_we = 1'b1; data_we = 1'b1; wdata = 8'h1A;
    @(negedge clk); idx_we = 1'b0; data_we = 1'b0; #1;
    chk("R1 new index selected, target untouched", rd_data, 8'h66);
    rd_reg(8'h17, v); chk("R1 old index written", v, 8'h1A);
  endtask

  task automatic t_relock;
    logic [7:0] v;
    wr_reg(8'h03, 8'h00);
    wr_reg(8'h10, 8'h11);
    rd_reg(8'h10, v); chk("R12 read while locked", v, 8'hA5);
    rd_reg(8'h10, v); chk("R12 repeat read no effect", v, 8'hA5);
    wr_reg(8'h19, 8'h01);
    chk("R4 no smm strobe locked", smm, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_locked();
    t_unlock();
    t_masks();
    t_full();
    t_cache_p92();
    t_strobe();
    t_irq();
    t_conflict();
    t_same_cycle();
    t_relock();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule